// File: doc/BRIEF.md
# Boundary-Window Gap and Cubic LMS Calibrator

This block watches the output stream of a two-stage noise-shaped converter, one word per conversion. Alongside each output word it receives the coarse code and fourteen window flags, one per coarse decision boundary. A flag is raised only when the input fell in a narrow window around that boundary. Flagged words are sorted, by their coarse code, into an upper-edge or a lower-edge accumulator for the boundary. All other words are discarded. Once a programmed number of words has been sorted, a sequencer turns the accumulators into one gap estimate per boundary. The gap estimate is the upper-edge mean minus the lower-edge mean.

Boundaries come in mirrored pairs, plus i and minus i. The half-sum of a pair's gaps drives a least-mean-squares loop for that pair's linear gap coefficient. The half-differences of all pairs drive one shared loop for a cubic coefficient. After the update, the block rebuilds a fifteen-entry coarse correction table and clears its accumulators for the next cycle. The surrounding datapath looks up the corrected coarse value in this table. It feeds the cubic coefficient to a separate correction stage.

Top module: `gap_lms_cal`

## Requirements
- R1: A word with `in_valid` low, or with all `flags` low, is not sorted and does not change any estimate or the sample count.
- R2: Flag bit b<7 belongs to boundary +(b+1). Its upper edge is coarse code b+1 and its lower edge is code b. Flag bit b>=7 belongs to boundary -(b-6). Its upper edge is code -(b-7) and its lower edge is code -(b-6). A flagged word whose coarse code matches neither edge is not sorted.
- R3: The gap of a boundary is the sum of its upper-edge words divided by their count, minus the same for the lower edge, with division truncating toward zero.
- R4: For pair i, the error e = (k+i + k-i) >>> 1. The coefficient update is beta_i += e >>> mu_shift.
- R5: The cubic error is the sum over updated pairs of (k+i - k-i) >>> 1. The update is gamma += error >>> mu_shift.
- R6: A calibration cycle ends on the clock edge at which the count of sorted words reaches `cal_total`.
- R7: If any of the four edge sets of a pair is empty at cycle end, that pair's beta is held and the pair is left out of the cubic error.
- R8: Table entry j (`lut_sel` = j, signed, -7..7) equals j*STEP - sign(j)*(beta_1 + ... + beta_|j|). Entry 0 is zero.
- R9: `cal_done` pulses for one cycle after each update. Each cycle's estimates use only the words sorted during that cycle.
- R10: Coefficient updates saturate at the signed CW-bit limits instead of wrapping.
- R11: After reset, all betas and gamma read zero, table entry j reads j*STEP, and `cal_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A conversion result is present |
| dout | input | DW | Final output word, signed |
| coarse | input | 4 | Coarse code, signed, -7..7 |
| flags | input | 14 | Boundary window flags |
| cal_total | input | CNTW | Sorted words per calibration cycle |
| mu_shift | input | 4 | LMS step-size exponent |
| beta_sel | input | 3 | Selects pair coefficient beta_(sel+1) |
| lut_sel | input | 4 | Signed table index, -7..7 |
| beta_val | output | CW | Selected pair coefficient |
| gamma_val | output | CW | Cubic coefficient |
| lut_val | output | DW | Table entry at `lut_sel` |
| cal_done | output | 1 | One-cycle end-of-cycle pulse |

## Verification
Saturation is the hardest condition to reach. In the normal closed loop, the correction table feeds back into the output words, and every gap is pulled toward zero long before a coefficient nears its limit. The stimulus reaches saturation by injecting a first-pair gap far beyond the coefficient range and a second-pair gap far beyond it in the negative direction, with a step exponent of zero. Both coefficients then clip on the first update and stay clipped on the next one. A separate cycle omits one edge of a single boundary, so that the held-pair rule shows up as one stale coefficient and a smaller cubic update.

// File: rtl/gap_lms_cal.sv
module gap_lms_cal #(
  parameter int DW   = 18,
  parameter int CW   = 16,
  parameter int CNTW = 12,
  parameter int STEP = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   dout,
  input  logic signed [3:0]      coarse,
  input  logic [13:0]            flags,
  input  logic [CNTW-1:0]        cal_total,
  input  logic [3:0]             mu_shift,
  input  logic [2:0]             beta_sel,
  input  logic signed [3:0]      lut_sel,
  output logic signed [CW-1:0]   beta_val,
  output logic signed [CW-1:0]   gamma_val,
  output logic signed [DW-1:0]   lut_val,
  output logic                   cal_done
);
  localparam int SW = DW + CNTW;
  localparam int EW = SW + 4;
  localparam int NB = 7;
  localparam int NF = 2 * NB;
  localparam logic signed [EW-1:0] CMAX = EW'((64'sd1 <<< (CW - 1)) - 64'sd1);
  localparam logic signed [EW-1:0] CMIN = -CMAX - EW'(1);

  typedef enum logic [2:0] {S_ACC, S_EST, S_GAM, S_LUT, S_CLR} st_t;
  st_t state;

  logic signed [SW-1:0] sum_u [NF];
  logic signed [SW-1:0] sum_l [NF];
  logic [CNTW-1:0]      cnt_u [NF];
  logic [CNTW-1:0]      cnt_l [NF];
  logic [CNTW-1:0]      sample_cnt;
  logic signed [CW-1:0] beta [NB];
  logic signed [CW-1:0] gamma_r;
  logic signed [DW-1:0] lut_r [NF+1];
  logic signed [DW-1:0] lut_nx [NF+1];
  logic signed [EW-1:0] gerr, cum;
  logic [2:0]           pidx;
  logic [NF-1:0]        hit_u, hit_l;

  function automatic logic signed [4:0] up_code(input int b);
    return (b < NB) ? 5'(b + 1) : 5'(NB - b);
  endfunction
  function automatic logic signed [4:0] lo_code(input int b);
    return (b < NB) ? 5'(b) : 5'(NB - 1 - b);
  endfunction
  function automatic logic signed [CW-1:0] sat(input logic signed [EW-1:0] v);
    if (v > CMAX) return CW'(CMAX);
    if (v < CMIN) return CW'(CMIN);
    return CW'(v);
  endfunction

  always_comb
    for (int b = 0; b < NF; b++) begin
      hit_u[b] = flags[b] && ($signed({coarse[3], coarse}) == up_code(b));
      hit_l[b] = flags[b] && ($signed({coarse[3], coarse}) == lo_code(b));
    end

  wire accept = in_valid && (state == S_ACC);
  wire sorted = |(hit_u | hit_l);

  wire [3:0] pi = {1'b0, pidx};
  wire [3:0] ni = {1'b0, pidx} + 4'd7;
  wire pvalid = (cnt_u[pi] != 0) && (cnt_l[pi] != 0) && (cnt_u[ni] != 0) && (cnt_l[ni] != 0);

  function automatic logic signed [SW-1:0] mean(input logic signed [SW-1:0] s, input logic [CNTW-1:0] c);
    return s / $signed({1'b0, (c == 0) ? CNTW'(1) : c});
  endfunction

  wire signed [SW:0]   kp   = (SW+1)'(mean(sum_u[pi], cnt_u[pi])) - (SW+1)'(mean(sum_l[pi], cnt_l[pi]));
  wire signed [SW:0]   kn   = (SW+1)'(mean(sum_u[ni], cnt_u[ni])) - (SW+1)'(mean(sum_l[ni], cnt_l[ni]));
  wire signed [EW-1:0] elin = (EW'(kp) + EW'(kn)) >>> 1;
  wire signed [EW-1:0] ecub = (EW'(kp) - EW'(kn)) >>> 1;

  always_comb begin
    cum = '0;
    lut_nx[NB] = '0;
    for (int j = 1; j <= NB; j++) begin
      cum = cum + EW'(beta[j-1]);
      lut_nx[NB+j] = DW'(EW'(j * STEP) - cum);
      lut_nx[NB-j] = DW'(cum - EW'(j * STEP));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_ACC;
      sample_cnt <= '0;
      pidx <= '0;
      gerr <= '0;
      gamma_r <= '0;
      for (int b = 0; b < NF; b++) begin
        sum_u[b] <= '0; sum_l[b] <= '0; cnt_u[b] <= '0; cnt_l[b] <= '0;
      end
      for (int p = 0; p < NB; p++) beta[p] <= '0;
      for (int k = 0; k <= NF; k++) lut_r[k] <= DW'((k - NB) * STEP);
    end else begin
      case (state)
        S_ACC: if (accept && sorted) begin
          for (int b = 0; b < NF; b++) begin
            if (hit_u[b]) begin sum_u[b] <= sum_u[b] + SW'(dout); cnt_u[b] <= cnt_u[b] + 1'b1; end
            if (hit_l[b]) begin sum_l[b] <= sum_l[b] + SW'(dout); cnt_l[b] <= cnt_l[b] + 1'b1; end
          end
          sample_cnt <= sample_cnt + 1'b1;
          if (sample_cnt + 1'b1 == cal_total) begin
            state <= S_EST;
            pidx <= '0;
            gerr <= '0;
          end
        end
        S_EST: begin
          if (pvalid) begin
            beta[pidx] <= sat(EW'(beta[pidx]) + (elin >>> mu_shift));
            gerr <= gerr + ecub;
          end
          pidx <= pidx + 1'b1;
          if (pidx == 3'(NB - 1)) state <= S_GAM;
        end
        S_GAM: begin
          gamma_r <= sat(EW'(gamma_r) + (gerr >>> mu_shift));
          state <= S_LUT;
        end
        S_LUT: begin
          for (int k = 0; k <= NF; k++) lut_r[k] <= lut_nx[k];
          state <= S_CLR;
        end
        default: begin
          for (int b = 0; b < NF; b++) begin
            sum_u[b] <= '0; sum_l[b] <= '0; cnt_u[b] <= '0; cnt_l[b] <= '0;
          end
          sample_cnt <= '0;
          state <= S_ACC;
        end
      endcase
    end
  end

  wire [3:0] lidx = 4'(lut_sel) + 4'd7;
  assign beta_val  = beta[beta_sel];
  assign gamma_val = gamma_r;
  assign lut_val   = lut_r[lidx];
  assign cal_done  = (state == S_CLR);

  a_r1_unflagged_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACC && in_valid && flags == '0) |=> $stable(sample_cnt));
  a_r6_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_ACC && state != S_CLR) |=> $stable(sample_cnt));
  a_r9_done_after_table: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> $past(state) == S_LUT);
  a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> (sample_cnt == '0));
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GAM && gerr >= 0) |=> gamma_r >= $past(gamma_r));
  a_r4_beta_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACC) |=> $stable(beta[0]) && $stable(beta[6]));
endmodule

// File: tb/tb_gap_lms_cal.sv
module tb_gap_lms_cal;
  localparam int DW = 18, CW = 16, CNTW = 12, STEP = 256, H = STEP / 2;

  logic clk = 0, rst_n = 0, in_valid = 0, cal_done;
  logic signed [DW-1:0] dout = '0;
  logic signed [3:0] coarse = '0, lut_sel = '0;
  logic [13:0] flags = '0;
  logic [CNTW-1:0] cal_total = '0;
  logic [3:0] mu_shift = '0;
  logic [2:0] beta_sel = '0;
  logic signed [CW-1:0] beta_val, gamma_val;
  logic signed [DW-1:0] lut_val;

  gap_lms_cal #(.DW(DW), .CW(CW), .CNTW(CNTW), .STEP(STEP)) dut (
    .clk, .rst_n, .in_valid, .dout, .coarse, .flags, .cal_total, .mu_shift,
    .beta_sel, .lut_sel, .beta_val, .gamma_val, .lut_val, .cal_done);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int exp_q[$];
  string tag_q[$];
  longint mb[7], mg;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint satc(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint mlut(int j);
    longint c = 0;
    for (int b = 1; b <= (j < 0 ? -j : j); b++) c += mb[b-1];
    return (j >= 0) ? longint'(j) * STEP - c : longint'(j) * STEP + c;
  endfunction

  task automatic send(logic v, longint d, int c, logic [13:0] f);
    @(negedge clk);
    in_valid = v; dout = DW'(d); coarse = 4'(c); flags = f;
  endtask

  // one calibration cycle: pair gaps B, cubic term G, noise n, optional missing upper edge
  task automatic run_cycle(longint B[7], longint G, int n, int mu, int skip_b, string tag);
    longint kp[7], kn[7], g, eg = 0;
    int total = 0;
    mu_shift = 4'(mu);
    for (int p = 0; p < 7; p++) begin
      kp[p] = B[p] + G - mg - mb[p];
      kn[p] = B[p] - G + mg - mb[p];
    end
    total = (skip_b >= 0) ? 54 : 56;
    cal_total = CNTW'(total);
    // R1: junk that must be ignored
    send(1, 99999, 3, 14'h0);
    send(0, 88888, 1, 14'h1);
    // R2: flagged word with a code matching neither edge
    send(1, 77777, 5, 14'h1);
    for (int b = 0; b < 14; b++) begin
      int p = b % 7;
      int hi = (b < 7) ? b + 1 : 7 - b;
      int lo = (b < 7) ? b : 6 - b;
      g = B[p] + ((b < 7) ? (G - mg) : (mg - G));
      send(1, mlut(lo) + H + n, lo, 14'(1) << b);
      send(1, mlut(lo) + H - n, lo, 14'(1) << b);
      if (b != skip_b) begin
        send(1, mlut(hi) - H + g + n, hi, 14'(1) << b);
        send(1, mlut(hi) - H + g - n, hi, 14'(1) << b);
      end
    end
    for (int p = 0; p < 7; p++)
      if (!(skip_b >= 0 && p == skip_b % 7)) begin
        mb[p] = satc(mb[p] + (((kp[p] + kn[p]) >>> 1) >>> mu));
        eg += (kp[p] - kn[p]) >>> 1;
      end
    mg = satc(mg + (eg >>> mu));
    for (int p = 0; p < 7; p++) begin exp_q.push_back(int'(mb[p])); tag_q.push_back(tag); end
    exp_q.push_back(int'(mg)); tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 0; flags = '0;
    while (!cal_done) @(negedge clk);
    @(negedge clk);
    for (int j = -7; j <= 7; j++) begin
      lut_sel = 4'(j); #1;
      check($sformatf("R8 lut[%0d] %s", j, tag), longint'(lut_val), mlut(j));
    end
  endtask

  // monitor: scoreboard pop on each completion pulse
  initial forever begin
    @(negedge clk);
    if (cal_done) begin
      for (int k = 0; k < 8; k++) begin
        string t;
        int e;
        longint a;
        if (exp_q.size() == 0) begin
          check("R9 unexpected completion", 1, 0);
          break;
        end
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (k < 7) begin beta_sel = 3'(k); #1; a = beta_val; end
        else a = gamma_val;
        check($sformatf("%s coef%0d", t, k), a, e);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint B[7];
    foreach (mb[p]) mb[p] = 0;
    mg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    for (int p = 0; p < 7; p++) begin beta_sel = 3'(p); #1; check("R11 beta", beta_val, 0); end
    check("R11 gamma", gamma_val, 0);
    check("R11 done", cal_done, 0);
    for (int j = -7; j <= 7; j++) begin lut_sel = 4'(j); #1; check("R11 lut", lut_val, j * STEP); end

    B = '{40, -24, 64, 10, -8, 30, 16};
    run_cycle(B, 12, 5, 2, -1, "R3 R4 R5 R6 first");
    for (int c = 0; c < 14; c++) run_cycle(B, 12, 3 + c, 2, -1, "R4 R5 R9 track");
    for (int p = 0; p < 7; p++) begin
      longint d;
      beta_sel = 3'(p); #1;
      d = B[p] - beta_val;
      check("R4 converged", (d < 4 && d > -4), 1);
    end
    check("R5 converged", ((gamma_val - 12) < 4 && (gamma_val - 12) > -4), 1);

    B = '{100, -24, 64, 10, -8, 30, 16};
    run_cycle(B, 20, 2, 1, 9, "R7 held pair");

    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    foreach (mb[p]) mb[p] = 0;
    mg = 0;
    B = '{40000, -40000, 0, 0, 0, 0, 0};
    run_cycle(B, 0, 1, 0, -1, "R10 saturate");
    run_cycle(B, 0, 1, 0, -1, "R10 stay");

    repeat (4) @(negedge clk);
    check("R9 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule